// File: doc/BRIEF.md
# Strided Banked Vector Load Engine

This block executes one strided vector load at a time. A command supplies a starting word address, a signed word stride, an element count and a destination vector register. The engine walks the elements in order, forming each element's word address and presenting it to a memory that is interleaved across sixteen banks of 64-bit words. Each bank stays occupied for a few cycles after it accepts an access. The engine keeps its own per-bank occupancy counters and holds back the next element whenever that element's bank is still occupied. As a result, strides that keep landing on one bank run at a fraction of the full rate.

The memory answers every access after a fixed delay and echoes the element index with the data. The engine turns each answer into a write on its vector register write port: destination register, element slot and data word. When the final element has been written, a completion flag rises. It stays high until the next command is taken.

Top module: `vec_stride_loader`

## Requirements
- R1: The word address presented for element i equals the command base plus i times the command stride, computed modulo 2^ADDR_W. The stride is taken as two's complement, so negative strides walk downward.
- R2: The target bank of an access is the low 4 bits of its word address. After a bank accepts an access in some cycle, no further access goes to that bank in any of the next 3 cycles.
- R3: At most one access is presented per cycle, in ascending element order. Element 0 goes out in the first cycle after the command is accepted, unless its bank is occupied. Every later element goes out at the earliest cycle that is both after the previous element's cycle and allowed by R2.
- R4: With a stride of 0 or 16, all accesses hit a single bank and consecutive accesses are exactly 4 cycles apart.
- R5: A command with count VL produces exactly VL accesses, tagged 0 to VL-1. A count above MAX_VL (64) is treated as MAX_VL.
- R6: A memory answer in cycle c carrying tag t and data d produces, in cycle c+1, a write strobe with element slot t, data d and the command's destination register.
- R7: The done flag rises in the cycle after the write of the last element and stays high until the next command is accepted. Accepting a nonzero-count command clears it. A count of 0 raises done in the cycle after acceptance and produces no access.
- R8: cmdReady is high only while no command is in progress. A command presented while cmdReady is low has no effect on accesses, writes or done.
- R9: After reset, cmdReady is 1, and done, memReqValid and wrEn are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Engine idle, command taken when cmdValid is also high |
| cmdBase | input | ADDR_W | Word address of element 0 |
| cmdStride | input | ADDR_W | Signed stride in words |
| cmdVl | input | VL_W | Number of elements |
| cmdDest | input | REG_W | Destination vector register |
| memReqValid | output | 1 | Access presented and accepted this cycle |
| memReqAddr | output | ADDR_W | Word address of the access |
| memReqTag | output | IDX_W | Element index of the access |
| memRspValid | input | 1 | Memory answer present |
| memRspTag | input | IDX_W | Element index echoed by memory |
| memRspData | input | DATA_W | Data word returned |
| wrEn | output | 1 | Vector register write strobe |
| wrReg | output | REG_W | Register being written |
| wrElem | output | IDX_W | Element slot being written |
| wrData | output | DATA_W | Data being written |
| done | output | 1 | Last element written, held until next command |

## Verification
In every command longer than the memory delay, issuing a new access and writing back an earlier answer happen in the same cycle. The 64-element unit-stride command keeps both busy for about fifty overlapping cycles. During these overlaps, the bench checks each presented address and its cycle against a model of bank occupancy built from the requirements. It also checks each write against a queue of expected slots and data filled when the command is issued. A corrupted write or a mistimed access in an overlap cycle therefore shows up as a miscompare on one side or the other.

// File: rtl/vsl_pkg.sv
package vsl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_LAST  = 2'd3
  } ldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new command
    logic issue;  // an element access leaves this cycle
  } ldStrobe_t;

endpackage

// File: rtl/vsl_bank_tracker.sv
module vsl_bank_tracker #(
  parameter int NUM_BANKS   = 16,
  parameter int BUSY_CYCLES = 4,
  parameter int BANK_W      = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              issue,
  output logic              bankBusy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES) + 1;

  logic [CNT_W-1:0] holdCnt [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdCnt[b] <= '0;
      end else if (issue && (bankSel == BANK_W'(b))) begin
        holdCnt[b] <= CNT_W'(BUSY_CYCLES - 1);
      end else if (holdCnt[b] != '0) begin
        holdCnt[b] <= holdCnt[b] - 1'b1;
      end
    end
  end

  assign bankBusy = (holdCnt[bankSel] != '0);

endmodule

// File: rtl/vsl_ctrl.sv
module vsl_ctrl
  import vsl_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int IDX_W  = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [VL_W-1:0]  cmdVl,
  input  logic             bankBusy,
  input  logic             memRspValid,
  output logic             cmdReady,
  output logic             memReqValid,
  output logic [IDX_W-1:0] memReqTag,
  output logic             done,
  output ldStrobe_t        strobes
);
  ldState_t        state;
  logic [VL_W-1:0] vlReg;
  logic [VL_W-1:0] issueCnt;
  logic [VL_W-1:0] rcvCnt;
  logic [VL_W-1:0] effVl;
  logic            accept;
  logic            reqFire;

  assign effVl    = (cmdVl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : cmdVl;
  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdValid && cmdReady;
  assign reqFire  = (state == ST_ISSUE) && !bankBusy;

  assign memReqValid   = reqFire;
  assign memReqTag     = issueCnt[IDX_W-1:0];
  assign strobes.load  = accept;
  assign strobes.issue = reqFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      vlReg    <= '0;
      issueCnt <= '0;
      rcvCnt   <= '0;
      done     <= 1'b0;
    end else begin
      if (memRspValid && (state != ST_IDLE)) begin
        rcvCnt <= rcvCnt + 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (accept) begin
            vlReg    <= effVl;
            issueCnt <= '0;
            rcvCnt   <= '0;
            done     <= (effVl == '0);
            state    <= (effVl == '0) ? ST_IDLE : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (reqFire) begin
            issueCnt <= issueCnt + 1'b1;
            if (issueCnt == VL_W'(vlReg - 1'b1)) begin
              state <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (memRspValid && (rcvCnt == VL_W'(vlReg - 1'b1))) begin
            state <= ST_LAST;
          end
        end
        ST_LAST: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vsl_datapath.sv
module vsl_datapath
  import vsl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 6,
  parameter int REG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobe_t         strobes,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [ADDR_W-1:0] cmdStride,
  input  logic [REG_W-1:0]  cmdDest,
  input  logic              memRspValid,
  input  logic [IDX_W-1:0]  memRspTag,
  input  logic [DATA_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              wrEn,
  output logic [REG_W-1:0]  wrReg,
  output logic [IDX_W-1:0]  wrElem,
  output logic [DATA_W-1:0] wrData
);
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] strideReg;
  logic [REG_W-1:0]  destReg;

  // address walker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      strideReg <= '0;
      destReg   <= '0;
    end else if (strobes.load) begin
      curAddr   <= cmdBase;
      strideReg <= cmdStride;
      destReg   <= cmdDest;
    end else if (strobes.issue) begin
      curAddr <= curAddr + strideReg;
    end
  end

  assign memReqAddr = curAddr;

  // register write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrReg  <= '0;
      wrElem <= '0;
      wrData <= '0;
    end else begin
      wrEn <= memRspValid;
      if (memRspValid) begin
        wrReg  <= destReg;
        wrElem <= memRspTag;
        wrData <= memRspData;
      end
    end
  end

endmodule

// File: rtl/vec_stride_loader.sv
module vec_stride_loader
  import vsl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int MAX_VL      = 64,
  parameter int NUM_REGS    = 8,
  parameter int NUM_BANKS   = 16,
  parameter int BUSY_CYCLES = 4,
  parameter int VL_W        = $clog2(MAX_VL + 1),
  parameter int IDX_W       = $clog2(MAX_VL),
  parameter int REG_W       = $clog2(NUM_REGS),
  parameter int BANK_W      = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [ADDR_W-1:0] cmdStride,
  input  logic [VL_W-1:0]   cmdVl,
  input  logic [REG_W-1:0]  cmdDest,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [IDX_W-1:0]  memReqTag,
  input  logic              memRspValid,
  input  logic [IDX_W-1:0]  memRspTag,
  input  logic [DATA_W-1:0] memRspData,
  output logic              wrEn,
  output logic [REG_W-1:0]  wrReg,
  output logic [IDX_W-1:0]  wrElem,
  output logic [DATA_W-1:0] wrData,
  output logic              done
);
  ldStrobe_t strobes;
  logic      bankBusy;

  vsl_ctrl #(
    .MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdVl(cmdVl),
    .bankBusy(bankBusy), .memRspValid(memRspValid),
    .cmdReady(cmdReady), .memReqValid(memReqValid),
    .memReqTag(memReqTag), .done(done), .strobes(strobes)
  );

  vsl_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cmdBase(cmdBase), .cmdStride(cmdStride), .cmdDest(cmdDest),
    .memRspValid(memRspValid), .memRspTag(memRspTag), .memRspData(memRspData),
    .memReqAddr(memReqAddr),
    .wrEn(wrEn), .wrReg(wrReg), .wrElem(wrElem), .wrData(wrData)
  );

  vsl_bank_tracker #(
    .NUM_BANKS(NUM_BANKS), .BUSY_CYCLES(BUSY_CYCLES), .BANK_W(BANK_W)
  ) u_banks (
    .clk(clk), .rstN(rstN),
    .bankSel(memReqAddr[BANK_W-1:0]),
    .issue(strobes.issue),
    .bankBusy(bankBusy)
  );

endmodule

// File: rtl/vsl_checker.sv
module vsl_checker #(
  parameter int BUSY_CYCLES = 4,
  parameter int VL_W        = 7,
  parameter int IDX_W       = 6,
  parameter int DATA_W      = 64,
  parameter int BANK_W      = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [VL_W-1:0]   cmdVl,
  input logic              memReqValid,
  input logic [BANK_W-1:0] reqBank,
  input logic [IDX_W-1:0]  memReqTag,
  input logic              memRspValid,
  input logic [IDX_W-1:0]  memRspTag,
  input logic [DATA_W-1:0] memRspData,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrElem,
  input logic [DATA_W-1:0] wrData,
  input logic              done
);

  if (BUSY_CYCLES >= 4) begin : g_gap
    // R2: same bank never reused within three cycles
    a_r2_bank_gap1: assert property (@(posedge clk) disable iff (!rstN)
      (memReqValid && $past(memReqValid)) |-> (reqBank != $past(reqBank)));
    a_r2_bank_gap2: assert property (@(posedge clk) disable iff (!rstN)
      (memReqValid && $past(memReqValid, 2)) |-> (reqBank != $past(reqBank, 2)));
    a_r2_bank_gap3: assert property (@(posedge clk) disable iff (!rstN)
      (memReqValid && $past(memReqValid, 3)) |-> (reqBank != $past(reqBank, 3)));
  end

  // R3: back-to-back accesses carry consecutive element indices
  a_r3_tag_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && $past(memReqValid) && (memReqTag != '0))
      |-> (memReqTag == IDX_W'($past(memReqTag) + 1'b1)));

  // R6: every answer becomes a write one cycle later
  a_r6_write_follows: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |=> (wrEn && (wrElem == $past(memRspTag)) && (wrData == $past(memRspData))));

  // R7: accepting a nonzero command drops done, a zero count raises it
  a_r7_done_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && (cmdVl != '0)) |=> !done);
  a_r7_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && (cmdVl == '0)) |=> (done && !memReqValid));

  // R8: no access while idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !memReqValid);

endmodule

bind vec_stride_loader vsl_checker #(
  .BUSY_CYCLES(BUSY_CYCLES), .VL_W(VL_W), .IDX_W(IDX_W),
  .DATA_W(DATA_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdVl(cmdVl), .memReqValid(memReqValid),
  .reqBank(memReqAddr[BANK_W-1:0]), .memReqTag(memReqTag),
  .memRspValid(memRspValid), .memRspTag(memRspTag), .memRspData(memRspData),
  .wrEn(wrEn), .wrElem(wrElem), .wrData(wrData), .done(done)
);

// File: tb/vec_stride_loader_bench.sv
module vec_stride_loader_bench;

  localparam int LAT  = 12;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [31:0] cmdBase = '0;
  logic [31:0] cmdStride = '0;
  logic [6:0]  cmdVl = '0;
  logic [2:0]  cmdDest = '0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic [5:0]  memReqTag;
  logic        memRspValid = 1'b0;
  logic [5:0]  memRspTag = '0;
  logic [63:0] memRspData = '0;
  logic        wrEn;
  logic [2:0]  wrReg;
  logic [5:0]  wrElem;
  logic [63:0] wrData;
  logic        done;

  vec_stride_loader u_vec_stride_loader (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdBase(cmdBase), .cmdStride(cmdStride), .cmdVl(cmdVl), .cmdDest(cmdDest),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqTag(memReqTag),
    .memRspValid(memRspValid), .memRspTag(memRspTag), .memRspData(memRspData),
    .wrEn(wrEn), .wrReg(wrReg), .wrElem(wrElem), .wrData(wrData), .done(done)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; logic [5:0] tag; logic [63:0] data; } pend_t;
  typedef struct { logic [2:0] rg; logic [5:0] elem; logic [63:0] data; } expWr_t;
  pend_t  pend[$];
  expWr_t expQ[$];

  logic [31:0] curBase, curStride;
  int curVl = 0, expTag = 0, prevT = 0, acceptCyc = 0, reqSeen = 0, lastWrCyc = 0;
  int bankLast [16];

  function automatic logic [63:0] dataOf(logic [31:0] a);
    return {a ^ 32'hA5C3_0F17, ~a};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model, request checker and write monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (pend.size() > 0 && pend[0].due == cyc) begin
        memRspValid <= 1'b1;
        memRspTag   <= pend[0].tag;
        memRspData  <= pend[0].data;
        void'(pend.pop_front());
      end else begin
        memRspValid <= 1'b0;
      end
      if (memReqValid) begin
        logic [31:0] ea;
        int          b;
        int          et;
        ea = curBase + 32'(expTag) * curStride;
        b  = int'(ea[3:0]);
        et = (expTag == 0) ? acceptCyc + 1 : prevT + 1;
        if (bankLast[b] + BUSY > et) et = bankLast[b] + BUSY;
        check(expTag < curVl, "R5", "access beyond count", expTag, curVl);
        check(memReqTag == 6'(expTag), "R5", "tag", memReqTag, expTag);
        check(memReqAddr == ea, "R1", "address", memReqAddr, ea);
        if (curStride[3:0] == 4'd0)
          check(cyc == et, "R4", "single-bank issue cycle", cyc, et);
        else
          check(cyc == et, "R3", "issue cycle", cyc, et);
        bankLast[int'(memReqAddr[3:0])] = cyc;
        prevT = cyc;
        expTag++;
        reqSeen++;
        pend.push_back('{due: cyc + LAT, tag: memReqTag, data: dataOf(memReqAddr)});
      end
      if (wrEn) begin
        lastWrCyc = cyc;
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected write slot", wrElem, -1);
        end else begin
          expWr_t e;
          e = expQ.pop_front();
          check(wrElem == e.elem, "R6", "write slot", wrElem, e.elem);
          check(wrReg == e.rg, "R6", "write register", wrReg, e.rg);
          check(wrData == e.data, "R6", "write data", wrData, e.data);
        end
      end
    end
  end

  bit hadRun = 0;

  task automatic runCmd(logic [31:0] base, logic [31:0] stride, int vl, logic [2:0] dest, bit poke);
    int effVl;
    int waited;
    effVl = (vl > 64) ? 64 : vl;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    if (hadRun) check(done == 1'b1, "R7", "done held until next command", done, 1);
    cmdValid  = 1'b1;
    cmdBase   = base;
    cmdStride = stride;
    cmdVl     = 7'(vl);
    cmdDest   = dest;
    curBase   = base;
    curStride = stride;
    curVl     = effVl;
    expTag    = 0;
    reqSeen   = 0;
    acceptCyc = cyc;
    for (int i = 0; i < effVl; i++) begin
      logic [31:0] a;
      a = base + 32'(i) * stride;
      expQ.push_back('{rg: dest, elem: 6'(i), data: dataOf(a)});
    end
    @(negedge clk);
    cmdValid = 1'b0;
    check(cmdReady == (effVl == 0), "R8", "ready after accept", cmdReady, effVl == 0);
    waited = 0;
    while (!done && waited < 400) begin
      if (poke && waited >= 2 && waited < 6) begin
        cmdValid = 1'b1; cmdBase = 32'h7777; cmdStride = 32'd5;
        cmdVl = 7'd3; cmdDest = ~dest;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    cmdValid = 1'b0;
    check(done == 1'b1, "R7", "done within timeout", done, 1);
    if (effVl == 0)
      check(cyc == acceptCyc + 1, "R7", "zero count done cycle", cyc, acceptCyc + 1);
    else
      check(cyc == lastWrCyc + 1, "R7", "done cycle after last write", cyc, lastWrCyc + 1);
    check(reqSeen == effVl, "R5", "access count", reqSeen, effVl);
    check(expQ.size() == 0, "R6", "writes outstanding", expQ.size(), 0);
    expQ.delete();
    hadRun = 1;
  endtask

  initial begin
    for (int b = 0; b < 16; b++) bankLast[b] = -100;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(cmdReady == 1'b1, "R9", "cmdReady", cmdReady, 1);
    check(done == 1'b0, "R9", "done", done, 0);
    check(memReqValid == 1'b0, "R9", "memReqValid", memReqValid, 0);
    check(wrEn == 1'b0, "R9", "wrEn", wrEn, 0);

    runCmd(32'd100, 32'd1, 20, 3'd3, 0);           // R3 full rate
    runCmd(32'd5, 32'd16, 6, 3'd1, 0);             // R4 stride 16
    runCmd(32'd7, 32'd0, 5, 3'd2, 0);              // R4 stride 0
    runCmd(32'd0, 32'd8, 8, 3'd4, 0);              // R2 two banks
    runCmd(32'd50, 32'hFFFF_FFFD, 10, 3'd5, 0);    // R1 negative stride
    runCmd(32'd9, 32'd1, 0, 3'd6, 0);              // R7 zero count
    runCmd(32'd200, 32'd1, 64, 3'd7, 1);           // R8 ignored command, overlap
    runCmd(32'd1000, 32'd3, 70, 3'd0, 0);          // R5 clamp
    runCmd(32'd31, 32'd4, 12, 3'd2, 0);            // R2 four banks
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule